// File: doc/BRIEF.md
# Single-Bank GPIO Controller with Half-Word Masked Writes

This block is one 32-pin general-purpose I/O bank that sits behind a small word-wide register bus. Software writes an output value register either whole or one 16-pin half at a time. In a half write, a per-pin mask protects the pins that should stay as they are. Because of this, a single pin can be flipped in one bus write, with no read-modify-write, and a second agent changing other pins of the same half cannot be overwritten.

Pin direction and pad drive are two separate controls. A pin drives its pad only when it is marked as an output and its drive-enable bit is also set. The live pin levels pass through a synchronizer and can be read at any time, whatever the direction. Two pins can be built as output-only: once they are made outputs, a write that would turn them back into inputs has no effect on them.

Top module: `gpio_bank`

## Requirements
- R1: After reset the output value, direction and drive-enable registers are all zero, so `pin_out` and `pin_oe` are zero and every pin is an input.
- R2: A write to word address 0 loads all 32 bits of `bus_wdata` into the output value register in one step. It shows on `pin_out` after the clock edge that takes the write, and address 0 reads back the same value.
- R3: A write to word address 1 treats `bus_wdata[31:16]` as a mask and `bus_wdata[15:0]` as data for pins 15..0. For each pin whose mask bit is 0 the output value takes the data bit. Where the mask bit is 1 the value is kept. Pins 31..16 do not change.
- R4: A write to word address 2 does the same for pins 31..16: mask bit `16+k` guards pin `16+k`, and data bit `k` is its new value. Pins 15..0 do not change.
- R5: Word address 3 holds the direction register, which can be read and written. A 1 in bit n makes pin n an output and a 0 makes it an input.
- R6: Word address 4 holds the drive-enable register, which can be read and written. `pin_oe[n]` is 1 only when both direction bit n and drive-enable bit n are 1.
- R7: Reading word address 5 returns the pin levels `pin_in` after a two-flop synchronizer. A change on `pin_in` is seen on the second clock edge after it, whatever the pin's direction. Writes to address 5 have no effect.
- R8: With the lock option on (the default), pins 7 and 8 cannot be made inputs once set as outputs. A direction write leaves a 1 in bits 7 and 8 in place, while the other bits of the same write take effect.
- R9: Addresses 1 and 2, and every address from 6 upward, read as zero. Writes to addresses 6 and above change no register.
- R10: `pin_out` always shows the output value register, whatever the direction. Only `pin_oe` decides whether the pad is driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Active-low reset, sampled on the clock |
| bus_addr | input | 4 | Word address of the register |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pin_in | input | 32 | Pad input levels (asynchronous) |
| pin_out | output | 32 | Pad output values |
| pin_oe | output | 32 | Pad drive enables, 1 = drive |

## Verification
The assertions check on every cycle that each masked half write produces exactly the mask-selected merge and leaves the other half alone, and that a whole-word write loads `pin_out` directly. They also check that nothing at the pads changes in a cycle without a write, that a locked pin never drops its output direction, and that the level register always holds `pin_in` from two edges earlier. The read map, the reset state, the zero reads of the write-only and unmapped addresses, and the gating of `pin_oe` by two separate registers are shown only by the bench's scenarios, which drive register sequences and compare the results against values worked out by hand.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int PINS = 32;
  localparam int HALF = PINS / 2;

  // register word addresses
  localparam int ADR_OUT_ALL = 0;
  localparam int ADR_OUT_LO  = 1;
  localparam int ADR_OUT_HI  = 2;
  localparam int ADR_DIR     = 3;
  localparam int ADR_DRV     = 4;
  localparam int ADR_LEVEL   = 5;

  // merge one masked half-word: mask bit 1 keeps the old bit
  function automatic logic [HALF-1:0] merge_half(input logic [HALF-1:0] old_v,
                                                 input logic [PINS-1:0] word);
    logic [HALF-1:0] keep;
    logic [HALF-1:0] data;
    keep = word[PINS-1:HALF];
    data = word[HALF-1:0];
    return (old_v & keep) | (data & ~keep);
  endfunction

  // direction update: locked bits can only be set, never cleared
  function automatic logic [PINS-1:0] next_dir(input logic [PINS-1:0] old_v,
                                               input logic [PINS-1:0] wr_v,
                                               input logic [PINS-1:0] lock);
    return wr_v | (old_v & lock);
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw,
  output logic [WIDTH-1:0] synced
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= raw;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign synced = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_out_reg.sv
module gpio_out_reg
  import gpio_bank_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_all,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic [PINS-1:0] wdata,
  output logic [PINS-1:0] out_q
);
  logic [HALF-1:0] lo_d, hi_d;

  always_comb begin
    lo_d = out_q[HALF-1:0];
    hi_d = out_q[PINS-1:HALF];
    if (wr_all) begin
      lo_d = wdata[HALF-1:0];
      hi_d = wdata[PINS-1:HALF];
    end
    if (wr_lo) lo_d = merge_half(out_q[HALF-1:0], wdata);
    if (wr_hi) hi_d = merge_half(out_q[PINS-1:HALF], wdata);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= {hi_d, lo_d};
  end
endmodule

// File: rtl/gpio_dir_ctrl.sv
module gpio_dir_ctrl
  import gpio_bank_pkg::*;
#(
  parameter logic [PINS-1:0] LOCK_MASK = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_dir,
  input  logic            wr_drv,
  input  logic [PINS-1:0] wdata,
  output logic [PINS-1:0] dir_q,
  output logic [PINS-1:0] drv_q,
  output logic [PINS-1:0] pad_oe
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q <= '0;
      drv_q <= '0;
    end else begin
      if (wr_dir) dir_q <= next_dir(dir_q, wdata, LOCK_MASK);
      if (wr_drv) drv_q <= wdata;
    end
  end

  assign pad_oe = dir_q & drv_q;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2,
  parameter bit LOCK_EN     = 1'b1,
  parameter int LOCK_PIN_A  = 7,
  parameter int LOCK_PIN_B  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [31:0]       pin_in,
  output logic [31:0]       pin_out,
  output logic [31:0]       pin_oe
);
  localparam logic [PINS-1:0] LOCK_MASK =
    LOCK_EN ? ((PINS'(1) << LOCK_PIN_A) | (PINS'(1) << LOCK_PIN_B)) : '0;

  // decoded write events, named for the checker
  logic wr_all, wr_lo, wr_hi, wr_dir, wr_drv;
  logic [PINS-1:0] out_q, dir_q, drv_q, level_q;

  assign wr_all = bus_wr && (bus_addr == ADDR_W'(ADR_OUT_ALL));
  assign wr_lo  = bus_wr && (bus_addr == ADDR_W'(ADR_OUT_LO));
  assign wr_hi  = bus_wr && (bus_addr == ADDR_W'(ADR_OUT_HI));
  assign wr_dir = bus_wr && (bus_addr == ADDR_W'(ADR_DIR));
  assign wr_drv = bus_wr && (bus_addr == ADDR_W'(ADR_DRV));

  gpio_out_reg u_out (
    .clk(clk), .rst_n(rst_n),
    .wr_all(wr_all), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .wdata(bus_wdata), .out_q(out_q)
  );

  gpio_dir_ctrl #(.LOCK_MASK(LOCK_MASK)) u_dir (
    .clk(clk), .rst_n(rst_n),
    .wr_dir(wr_dir), .wr_drv(wr_drv), .wdata(bus_wdata),
    .dir_q(dir_q), .drv_q(drv_q), .pad_oe(pin_oe)
  );

  gpio_in_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(pin_in), .synced(level_q)
  );

  always_comb begin
    unique case (int'(bus_addr))
      ADR_OUT_ALL: bus_rdata = out_q;
      ADR_DIR:     bus_rdata = dir_q;
      ADR_DRV:     bus_rdata = drv_q;
      ADR_LEVEL:   bus_rdata = level_q;
      default:     bus_rdata = '0;
    endcase
  end

  assign pin_out = out_q;
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int ADDR_W     = 4,
  parameter bit LOCK_EN    = 1'b1,
  parameter int LOCK_PIN_A = 7,
  parameter int LOCK_PIN_B = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       pin_in,
  input logic [31:0]       pin_out,
  input logic [31:0]       pin_oe,
  input logic [31:0]       dir_q,
  input logic [31:0]       level_q
);
  logic [1:0] up_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) up_cnt <= '0;
    else if (up_cnt != 2'd3) up_cnt <= up_cnt + 2'd1;
  end

  AST_FULL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == ADDR_W'(0) |=> pin_out == $past(bus_wdata)); // R2

  AST_LO_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == ADDR_W'(1) |=>
      pin_out[15:0] == (($past(pin_out[15:0]) & $past(bus_wdata[31:16])) |
                        ($past(bus_wdata[15:0]) & ~$past(bus_wdata[31:16])))); // R3

  AST_LO_SPARES_HI: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == ADDR_W'(1) |=> $stable(pin_out[31:16])); // R3

  AST_HI_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == ADDR_W'(2) |=>
      pin_out[31:16] == (($past(pin_out[31:16]) & $past(bus_wdata[31:16])) |
                         ($past(bus_wdata[15:0]) & ~$past(bus_wdata[31:16])))); // R4

  AST_HI_SPARES_LO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == ADDR_W'(2) |=> $stable(pin_out[15:0])); // R4

  AST_QUIET_PADS: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(pin_out) && $stable(pin_oe)); // R10

  AST_OE_NEEDS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & ~dir_q) == 32'h0); // R6

  AST_LEVEL_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    up_cnt == 2'd3 |-> level_q == $past(pin_in, 2)); // R7

  if (LOCK_EN) begin : g_lock
    AST_LOCK_A_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      dir_q[LOCK_PIN_A] |=> dir_q[LOCK_PIN_A]); // R8
    AST_LOCK_B_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      dir_q[LOCK_PIN_B] |=> dir_q[LOCK_PIN_B]); // R8
  end
endmodule

bind gpio_bank gpio_bank_chk #(
  .ADDR_W(ADDR_W), .LOCK_EN(LOCK_EN),
  .LOCK_PIN_A(LOCK_PIN_A), .LOCK_PIN_B(LOCK_PIN_B)
) u_gpio_bank_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .pin_in(pin_in), .pin_out(pin_out),
  .pin_oe(pin_oe), .dir_q(dir_q), .level_q(level_q)
);

// File: tb/test_gpio_bank.sv
module test_gpio_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out;
  logic [31:0] pin_oe;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  gpio_bank i_gpio_bank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // {addr, write data, expected pin_out after the write}
  localparam int NV = 10;
  localparam logic [67:0] VEC [NV] = '{
    {4'd0, 32'hA5A5_5A5A, 32'hA5A5_5A5A},  // R2 whole word
    {4'd1, 32'hFFFF_1234, 32'hA5A5_5A5A},  // R3 all masked
    {4'd1, 32'h0000_1234, 32'hA5A5_1234},  // R3 none masked
    {4'd1, 32'h00FF_BEEF, 32'hA5A5_BE34},  // R3 low byte kept
    {4'd2, 32'hF0F0_0F0F, 32'hAFAF_BE34},  // R4 nibble mask
    {4'd2, 32'h0000_0000, 32'h0000_BE34},  // R4 clear upper half
    {4'd7, 32'hFFFF_FFFF, 32'h0000_BE34},  // R9 unmapped write
    {4'd5, 32'hFFFF_FFFF, 32'h0000_BE34},  // R7 read-only write
    {4'd0, 32'h0000_0001, 32'h0000_0001},  // R2 whole word
    {4'd2, 32'h7FFF_8000, 32'h8000_0001}   // R4 top pin only
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 pin_out", pin_out, 32'h0);
    check("R1 pin_oe", pin_oe, 32'h0);
    rd(4'd0, r); check("R1 out reg", r, 32'h0);
    rd(4'd3, r); check("R1 dir reg", r, 32'h0);
    rd(4'd4, r); check("R1 drive reg", r, 32'h0);

    // vector walk over output writes
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][67:64], VEC[i][63:32]);
      check($sformatf("R2/R3/R4 vector %0d pin_out", i), pin_out, VEC[i][31:0]);
      rd(4'd0, r);
      check($sformatf("R2 vector %0d readback", i), r, VEC[i][31:0]);
    end

    // R10 pins carry value while all inputs, no drive
    check("R10 value without drive", pin_oe, 32'h0);

    // R5 / R6 direction and drive enable
    wr(4'd3, 32'h0000_FFFF);
    rd(4'd3, r); check("R5 dir readback", r, 32'h0000_FFFF);
    check("R6 dir only, no drive", pin_oe, 32'h0);
    wr(4'd4, 32'h00FF_00FF);
    rd(4'd4, r); check("R6 drive readback", r, 32'h00FF_00FF);
    check("R6 pin_oe and", pin_oe, 32'h0000_00FF);

    // R8 locked pins
    wr(4'd3, 32'hFFFF_FFFF);
    wr(4'd3, 32'h0000_0000);
    rd(4'd3, r); check("R8 locked dir bits", r, 32'h0000_0180);
    check("R8 pin_oe after lock", pin_oe, 32'h0000_0080);
    wr(4'd3, 32'h0000_0001);
    rd(4'd3, r); check("R8 other bits follow", r, 32'h0000_0181);

    // R9 zero reads and unmapped writes
    rd(4'd1, r); check("R9 read addr1", r, 32'h0);
    rd(4'd2, r); check("R9 read addr2", r, 32'h0);
    rd(4'd6, r); check("R9 read addr6", r, 32'h0);
    rd(4'd15, r); check("R9 read addr15", r, 32'h0);
    wr(4'd11, 32'hFFFF_FFFF);
    rd(4'd3, r); check("R9 dir untouched", r, 32'h0000_0181);
    rd(4'd4, r); check("R9 drive untouched", r, 32'h00FF_00FF);

    // R7 synchronized levels, two-edge latency
    @(negedge clk);
    pin_in = 32'h1357_9BDF;
    bus_addr = 4'd5;
    @(negedge clk);
    rd(4'd5, r); check("R7 one edge still old", r, 32'h0);
    @(negedge clk);
    rd(4'd5, r); check("R7 two edges new", r, 32'h1357_9BDF);
    wr(4'd5, 32'h0);
    rd(4'd5, r); check("R7 write ignored", r, 32'h1357_9BDF);

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule